// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block sits between a data cache and the external bus. When a load misses the cache array, it sends one request to the bus. The request carries the double-word-aligned address of the missed load. The bus then returns the 32-byte line as four 64-bit beats. The first beat is the double-word the load asked for. Each later beat is the next double-word of the line, wrapping round modulo four. The waiting load gets its double-word in the same cycle that beat reaches the buffer, so it does not wait for the whole line. The other beats are gathered into a four-slot buffer, with one arrival flag per slot. One cycle after the last beat, the full line is written into the cache array in a single wide write.

Tag lookup is done outside this block, which receives its result as a hit flag together with the array's read data. The array keeps serving hits while a fill is in flight. A load to the line being filled is answered from the buffer if its double-word has already arrived, and is held otherwise. Only one fill can be outstanding, so a second miss is held until the buffer is free. Loads signal their wait through a stall output and keep presenting the same address until they are served.

Top module: `line_fill_buffer`

## Requirements
- R1: After reset the block is idle: busReqValid, arrayWrEn, rspValid and ldStall are all 0 while no load is presented.
- R2: With no fill active, a load flagged ldHit is answered in the same cycle (rspValid=1, rspData=hitData, ldStall=0).
- R3: A load that is neither a hit nor on the line being filled, presented while idle, raises busReqValid for that cycle. busReqAddr is the load address with bits [2:0] cleared. The load is stalled in that cycle.
- R4: A line is split into four double-word slots, selected by address bits [4:3]. Beat k of a fill (counting from 0) goes into slot (critical slot + k) mod 4. The critical slot is bits [4:3] of the missed address.
- R5: A load to the line being filled whose slot is arriving in the current cycle is answered in that cycle, with rspData equal to beatData.
- R6: A load to the line being filled, or waiting to be written, whose slot has already arrived is answered in the same cycle from the buffer with no stall.
- R7: A load to the line being filled whose slot has neither arrived nor is arriving is stalled with rspValid=0.
- R8: In the cycle after the fourth beat, arrayWrEn is 1 for exactly one cycle. arrayWrAddr is then the line address with bits [4:0] cleared, and the fill then ends.
- R9: A load that misses while a fill or its line write is in progress is stalled and raises no bus request.
- R10: While a fill is in progress, loads that hit other lines in the array are answered in the same cycle with hitData.
- R11: The arrival flags are cleared when a fill starts, so no slot of the new line counts as arrived until its own beat comes.
- R12: arrayWrData holds slot i in bits [64i+63:64i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | A load is presented this cycle |
| ldAddr | input | ADDR_W | Byte address of the load |
| ldHit | input | 1 | Tag lookup found the load's line in the array |
| hitData | input | DATA_W | Double-word read from the array for a hit |
| ldStall | output | 1 | Load not served this cycle; hold it |
| rspValid | output | 1 | rspData carries the load's double-word |
| rspData | output | DATA_W | Load result |
| busReqValid | output | 1 | One-cycle request for a line fill |
| busReqAddr | output | ADDR_W | Double-word-aligned address of the missed load |
| beatValid | input | 1 | A fill beat is on beatData |
| beatData | input | DATA_W | One double-word of the line |
| arrayWrEn | output | 1 | Write the completed line into the array |
| arrayWrAddr | output | ADDR_W | Line-aligned address of the write |
| arrayWrData | output | 4*DATA_W | Completed line, slot 0 in the low bits |

## Verification
The bench uses the default 32-bit address and 64-bit double-word, with four slots per line. In this configuration, 3-bit random byte offsets and 2-bit slot numbers together reach every critical-slot position. Every wrap-around order of the burst therefore occurs, and a wrong slot rotation shows up both in forwarded data and in the wide line write. The loads are spread over eight lines, beats arrive with random gaps, and lines are evicted from the modelled array now and then. Together these produce hits during fills, loads held behind a busy buffer, and loads that land on a slot in its arrival cycle.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  localparam int unsigned LINE_DW = 4;
  localparam int unsigned SLOT_W  = $clog2(LINE_DW);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FILL  = 2'd1,
    FS_WRITE = 2'd2
  } fillState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic  start;      // open a new fill: latch tag, clear arrival flags
    logic  capture;    // store beatData into slot
    slot_t slot;       // slot the current beat belongs to
    logic  lineWrite;  // present the line to the array
  } fillStrobes_t;
endpackage

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ldValid,
  input  logic         ldHit,
  input  slot_t        ldSlot,
  input  logic         lineMatch,
  input  logic         slotAvail,
  input  logic         beatValid,
  output fillStrobes_t strobes,
  output logic         busReqValid,
  output logic         rspValid,
  output logic         useBuf,
  output logic         ldStall
);
  localparam slot_t LAST_CNT = slot_t'(LINE_DW - 1);

  fillState_t state;
  slot_t      beatCnt;
  slot_t      critSlot;
  logic       fillActive;
  logic       onLine;

  always_comb begin
    fillActive        = (state != FS_IDLE);
    onLine            = fillActive && lineMatch;
    strobes.start     = ldValid && !onLine && !ldHit && (state == FS_IDLE);
    strobes.capture   = beatValid && (state == FS_FILL);
    strobes.slot      = slot_t'(critSlot + beatCnt);
    strobes.lineWrite = (state == FS_WRITE);
    busReqValid       = strobes.start;
    useBuf            = onLine;
    rspValid          = ldValid && (onLine ? slotAvail : ldHit);
    ldStall           = ldValid && !rspValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      beatCnt  <= '0;
      critSlot <= '0;
    end else begin
      unique case (state)
        FS_IDLE: if (strobes.start) begin
          state    <= FS_FILL;
          beatCnt  <= '0;
          critSlot <= ldSlot;
        end
        FS_FILL: if (strobes.capture) begin
          beatCnt <= slot_t'(beatCnt + 1'b1);
          if (beatCnt == LAST_CNT) state <= FS_WRITE;
        end
        FS_WRITE: state <= FS_IDLE;
        default:  state <= FS_IDLE;
      endcase
    end
  end

  AST_MISS_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && !ldHit && !lineMatch && fillActive) |-> (ldStall && !busReqValid)); // R9
  AST_WRITE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && beatCnt == LAST_CNT) |=> strobes.lineWrite); // R8
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.lineWrite |=> !strobes.lineWrite); // R8
  AST_FIRST_BEAT_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.start |=> (strobes.slot == $past(ldSlot))); // R4
endmodule

// File: rtl/lfb_datapath.sv
module lfb_datapath
  import lfb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  fillStrobes_t              strobes,
  input  logic [ADDR_W-1:0]         ldAddr,
  input  logic [DATA_W-1:0]         beatData,
  input  logic [DATA_W-1:0]         hitData,
  input  logic                      useBuf,
  output slot_t                     ldSlot,
  output logic                      lineMatch,
  output logic                      slotAvail,
  output logic [DATA_W-1:0]         rspData,
  output logic [ADDR_W-1:0]         busReqAddr,
  output logic [ADDR_W-1:0]         arrayWrAddr,
  output logic [LINE_DW*DATA_W-1:0] arrayWrData
);
  localparam int unsigned BYTE_BITS = $clog2(DATA_W / 8);
  localparam int unsigned OFF_W     = BYTE_BITS + SLOT_W;
  localparam int unsigned TAG_W     = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] DW_MASK = ADDR_W'((1 << BYTE_BITS) - 1);

  logic [TAG_W-1:0]  lineTag;
  logic [TAG_W-1:0]  ldTag;
  logic [DATA_W-1:0] lineBuf [LINE_DW];
  logic [LINE_DW-1:0] arrMask;
  logic              arriveHere;
  logic [DATA_W-1:0] bufWord;

  always_comb begin
    ldTag       = ldAddr[ADDR_W-1:OFF_W];
    ldSlot      = ldAddr[OFF_W-1:BYTE_BITS];
    lineMatch   = (ldTag == lineTag);
    arriveHere  = strobes.capture && (strobes.slot == ldSlot);
    slotAvail   = arrMask[ldSlot] || arriveHere;
    bufWord     = arriveHere ? beatData : lineBuf[ldSlot];
    rspData     = useBuf ? bufWord : hitData;
    busReqAddr  = ldAddr & ~DW_MASK;
    arrayWrAddr = {lineTag, {OFF_W{1'b0}}};
  end

  for (genvar g = 0; g < LINE_DW; g++) begin : g_line
    assign arrayWrData[g*DATA_W +: DATA_W] = lineBuf[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineTag <= '0;
      arrMask <= '0;
    end else if (strobes.start) begin
      lineTag <= ldTag;
      arrMask <= '0;
    end else if (strobes.capture) begin
      arrMask[strobes.slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) lineBuf[strobes.slot] <= beatData;
  end

  AST_WRITE_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.lineWrite |-> (&arrMask)); // R8
  AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.start |=> (arrMask == '0)); // R11
  AST_SLOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |-> !arrMask[strobes.slot]); // R4
  AST_NO_START_MID_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.start && (strobes.capture || strobes.lineWrite))); // R9
endmodule

// File: rtl/line_fill_buffer.sv
module line_fill_buffer
  import lfb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ldValid,
  input  logic [ADDR_W-1:0]         ldAddr,
  input  logic                      ldHit,
  input  logic [DATA_W-1:0]         hitData,
  output logic                      ldStall,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData,
  output logic                      busReqValid,
  output logic [ADDR_W-1:0]         busReqAddr,
  input  logic                      beatValid,
  input  logic [DATA_W-1:0]         beatData,
  output logic                      arrayWrEn,
  output logic [ADDR_W-1:0]         arrayWrAddr,
  output logic [LINE_DW*DATA_W-1:0] arrayWrData
);
  fillStrobes_t strobes;
  slot_t        ldSlot;
  logic         lineMatch;
  logic         slotAvail;
  logic         useBuf;

  lfb_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ldValid     (ldValid),
    .ldHit       (ldHit),
    .ldSlot      (ldSlot),
    .lineMatch   (lineMatch),
    .slotAvail   (slotAvail),
    .beatValid   (beatValid),
    .strobes     (strobes),
    .busReqValid (busReqValid),
    .rspValid    (rspValid),
    .useBuf      (useBuf),
    .ldStall     (ldStall)
  );

  lfb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .ldAddr      (ldAddr),
    .beatData    (beatData),
    .hitData     (hitData),
    .useBuf      (useBuf),
    .ldSlot      (ldSlot),
    .lineMatch   (lineMatch),
    .slotAvail   (slotAvail),
    .rspData     (rspData),
    .busReqAddr  (busReqAddr),
    .arrayWrAddr (arrayWrAddr),
    .arrayWrData (arrayWrData)
  );

  assign arrayWrEn = strobes.lineWrite;

  AST_STALL_XOR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    ldValid |-> (ldStall != rspValid)); // R7
  AST_REQ_NOT_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    arrayWrEn |-> !busReqValid); // R9
endmodule

// File: tb/line_fill_buffer_tb.sv
module line_fill_buffer_tb;
  import lfb_pkg::*;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int LW = LINE_DW * DW;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          ldValid = 0;
  logic [AW-1:0] ldAddr = '0;
  logic          ldHit = 0;
  logic [DW-1:0] hitData = '0;
  logic          ldStall, rspValid, busReqValid, arrayWrEn;
  logic [DW-1:0] rspData;
  logic [AW-1:0] busReqAddr, arrayWrAddr;
  logic          beatValid = 0;
  logic [DW-1:0] beatData = '0;
  logic [LW-1:0] arrayWrData;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_fill_buffer u_dut (.*);

  function automatic logic [DW-1:0] lineData(int t, int s);
    return {16'hCAFE, 16'(t), 16'(s), 16'h5A5A};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  int phase = 0, fTag = 0, crit = 0, cnt = 0;
  bit arrived [4];
  logic [DW-1:0] mbuf [4];
  bit inArray [8];
  int curTag = 0, curSlot = 0;
  bit hold = 0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin arrived[i] = 0; mbuf[i] = '0; end
    for (int i = 0; i < 8; i++) inArray[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busReqValid && !arrayWrEn && !rspValid && !ldStall, "R1", "reset outputs",
        LW'({busReqValid, arrayWrEn, rspValid, ldStall}), '0);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!busReqValid && !arrayWrEn && !rspValid && !ldStall, "R1", "idle after reset",
        LW'({busReqValid, arrayWrEn, rspValid, ldStall}), '0);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit onLine, expRsp, expReq, arrHere, missCase;
      int arrSlot;
      logic [DW-1:0] expData;
      logic [LW-1:0] expLine;
      string tag;
      @(negedge clk);
      if (!hold) begin
        if ($urandom_range(9) < 7) begin
          curTag  = int'($urandom_range(7));
          curSlot = int'($urandom_range(3));
          ldAddr  = BASE + 32'(curTag * 32 + curSlot * 8) + 32'($urandom_range(7));
          ldValid = 1;
        end else ldValid = 0;
      end
      if ($urandom_range(15) == 0) begin
        int ev = int'($urandom_range(7));
        if (!(phase != 0 && ev == fTag)) inArray[ev] = 0;
      end
      onLine  = ldValid && phase != 0 && curTag == fTag;
      ldHit   = ldValid && !onLine && inArray[curTag];
      hitData = ldHit ? lineData(curTag, curSlot) : 64'hBAD0_BAD0_BAD0_BAD0;
      arrSlot = (crit + cnt) % 4;
      beatValid = (phase == 1) && ($urandom_range(1) == 1);
      beatData  = beatValid ? lineData(fTag, arrSlot) : 64'h0BAD_0BAD_0BAD_0BAD;
      #1;
      expRsp = 0; expData = '0; tag = "R2";
      missCase = ldValid && !onLine && !ldHit;
      if (ldValid) begin
        if (onLine) begin
          arrHere = beatValid && arrSlot == curSlot;
          if (arrived[curSlot] || arrHere) begin
            expRsp = 1;
            expData = arrHere ? beatData : mbuf[curSlot];
            tag = arrHere ? "R5" : "R6";
          end else tag = (cnt == 0) ? "R11" : "R7";
        end else if (ldHit) begin
          expRsp = 1; expData = hitData;
          tag = (phase != 0) ? "R10" : "R2";
        end else tag = (phase != 0) ? "R9" : "R3";
      end
      chk(rspValid == expRsp, tag, "rspValid", LW'(rspValid), LW'(expRsp));
      chk(ldStall == (ldValid && !expRsp), tag, "ldStall", LW'(ldStall), LW'(ldValid && !expRsp));
      if (expRsp) chk(rspData == expData, tag, "rspData", LW'(rspData), LW'(expData));
      expReq = missCase && phase == 0;
      chk(busReqValid == expReq, (missCase && phase != 0) ? "R9" : "R3", "busReqValid",
          LW'(busReqValid), LW'(expReq));
      if (expReq) chk(busReqAddr == (ldAddr & ~32'h7), "R3", "busReqAddr",
                      LW'(busReqAddr), LW'(ldAddr & ~32'h7));
      chk(arrayWrEn == (phase == 2), "R8", "arrayWrEn", LW'(arrayWrEn), LW'(phase == 2));
      if (phase == 2) begin
        for (int s = 0; s < 4; s++) expLine[s*DW +: DW] = mbuf[s];
        chk(arrayWrAddr == BASE + 32'(fTag * 32), "R8", "arrayWrAddr",
            LW'(arrayWrAddr), LW'(BASE + 32'(fTag * 32)));
        chk(arrayWrData == expLine, "R4", "arrayWrData slot order", arrayWrData, expLine);
        chk(arrayWrData == expLine, "R12", "arrayWrData layout", arrayWrData, expLine);
      end
      // advance the model to the state after this clock edge
      if (expReq) begin
        phase = 1; fTag = curTag; crit = curSlot; cnt = 0;
        for (int s = 0; s < 4; s++) arrived[s] = 0;
      end else if (phase == 1 && beatValid) begin
        mbuf[arrSlot] = beatData; arrived[arrSlot] = 1; cnt++;
        if (cnt == 4) phase = 2;
      end else if (phase == 2) begin
        phase = 0; inArray[fTag] = 1;
      end
      hold = ldValid && !expRsp;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule